// File: doc/BRIEF.md
# Thread-Masked Interval Timer

A per-core interval timer for a multithreaded processor core. One free-running up-counter is compared against a programmable limit. When the counter matches, the expiry is fanned out at once to every hardware thread selected by a writable thread-select mask. Each selected thread then sees a level interrupt on its own output line. A control bit can gate counting so that the counter stands still while the whole core is halted.

Software reaches the block through a small auxiliary-register port with read and write strobes, an address, write data and the ID of the thread that issues the access. A thread arms the timer in three steps: it writes the limit, zeroes the count, and then writes the control register with both the interrupt-enable and halt-gate bits set. It joins or leaves the interrupt set by a read-modify-write of the mask, using its own ID, which it can read back through the port. When the counter equals the limit, the next counting tick reloads it with zero, so the timer runs periodically until software reprograms it.

Top module: `thread_tick_timer`

## Requirements
- R1: After a synchronous reset, count, limit, control, mask, every interrupt output and the read data are all zero.
- R2: Reads return data one cycle after the read strobe, and hold that value until the next read. Count is at 0x21, control at 0x22 (bit 0 interrupt enable, bit 1 halt gate, upper bits read as zero), limit at 0x23, mask at 0x50 (bit n is thread n) and thread ID at 0x51. Any other address reads as zero.
- R3: A read and a write to the same register in the same cycle return the value held before the write.
- R4: On each counting tick the count increments by one. When the count equals the limit, the next tick loads zero instead.
- R5: A write to the count loads the written value and takes priority over the tick in that cycle.
- R6: With the halt gate (control bit 1) set and all thread_halted bits high, the count holds. With the gate clear, or any thread running, the count advances every cycle.
- R7: A tick with count equal to limit and interrupt enable (control bit 0) set is an expiry. On the following cycle, irq_out[n] is high for every thread n whose mask bit was set, and stays low for the others.
- R8: With interrupt enable clear, an expiry condition raises no interrupt.
- R9: An interrupt stays high until the mask is written with that thread's bit clear, or until the control register is written. A control write clears every pending interrupt and wins over a same-cycle expiry.
- R10: Reading address 0x51 returns the reg_tid value presented with the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (8) | Register address |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_tid | input | log2(NTHREADS) (4) | ID of the accessing thread |
| reg_rdata | output | DATA_W (32) | Registered read data |
| thread_halted | input | NTHREADS (16) | Per-thread halted status |
| irq_out | output | NTHREADS (16) | Per-thread level interrupt |

## Verification
A wrong count or limit shows up first as an interrupt at the wrong cycle. The bench model compares every irq_out bit on every clock, so a count that is off by one cycle is caught at the first expiry, at most limit+1 ticks later. A wrong mask or pending bit shows on the affected thread's line in the cycle after the next expiry or clearing write. Register state that does not reach the interrupts is brought out through readback, one cycle after each read.

// File: rtl/thread_tick_pkg.sv
`timescale 1ns/1ps
package thread_tick_pkg;
  localparam logic [7:0] ADDR_CNT  = 8'h21;
  localparam logic [7:0] ADDR_CTRL = 8'h22;
  localparam logic [7:0] ADDR_LIM  = 8'h23;
  localparam logic [7:0] ADDR_MASK = 8'h50;
  localparam logic [7:0] ADDR_TID  = 8'h51;

  typedef struct packed {
    logic gate_halt;  // bit 1
    logic irq_en;     // bit 0
  } tick_ctrl_t;
endpackage

// File: rtl/ttt_counter.sv
`timescale 1ns/1ps
module ttt_counter
  import thread_tick_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_we,
  input  logic          lim_we,
  input  logic          ctrl_we,
  input  logic [CW-1:0] wdata,
  input  tick_ctrl_t    ctrl_wdata,
  input  logic          core_halted,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] lim,
  output tick_ctrl_t    ctrl,
  output logic          expire
);
  logic tick;
  logic at_lim;

  assign tick   = !(ctrl.gate_halt && core_halted);
  assign at_lim = (cnt == lim);
  assign expire = tick && at_lim && ctrl.irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      lim  <= '0;
      ctrl <= '0;
    end else begin
      if (cnt_we)      cnt <= wdata;
      else if (tick)   cnt <= at_lim ? '0 : cnt + 1'b1;
      if (lim_we)      lim <= wdata;
      if (ctrl_we)     ctrl <= ctrl_wdata;
    end
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && at_lim && !cnt_we) |=> (cnt == '0)); // R4
  AST_HOLD_WHEN_GATED: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_we) |=> $stable(cnt)); // R6
  AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> (cnt == $past(wdata))); // R5
endmodule

// File: rtl/ttt_fanout.sv
`timescale 1ns/1ps
module ttt_fanout #(
  parameter int NT = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mask_we,
  input  logic [NT-1:0] mask_wdata,
  input  logic          ctrl_we,
  input  logic          expire,
  output logic [NT-1:0] mask,
  output logic [NT-1:0] pend
);
  for (genvar i = 0; i < NT; i++) begin : g_thr
    logic m_q;
    logic p_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        m_q <= 1'b0;
        p_q <= 1'b0;
      end else begin
        if (mask_we) m_q <= mask_wdata[i];
        if (ctrl_we)                         p_q <= 1'b0;
        else if (mask_we && !mask_wdata[i])  p_q <= 1'b0;
        else if (expire && m_q)              p_q <= 1'b1;
      end
    end
    assign mask[i] = m_q;
    assign pend[i] = p_q;
  end

  AST_PEND_WITHIN_MASK: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~mask) == '0)); // R7
  AST_CTRL_WR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ctrl_we |=> (pend == '0)); // R9
  AST_NO_RISE_WITHOUT_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    !expire |=> ((pend & ~$past(pend)) == '0)); // R8
endmodule

// File: rtl/thread_tick_timer.sv
`timescale 1ns/1ps
module thread_tick_timer
  import thread_tick_pkg::*;
#(
  parameter int NTHREADS = 16,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reg_wr_en,
  input  logic                        reg_rd_en,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  input  logic [$clog2(NTHREADS)-1:0] reg_tid,
  output logic [DATA_W-1:0]           reg_rdata,
  input  logic [NTHREADS-1:0]         thread_halted,
  output logic [NTHREADS-1:0]         irq_out
);
  localparam int TIDW = $clog2(NTHREADS);

  logic             sel_cnt, sel_ctrl, sel_lim, sel_mask, sel_tid;
  logic [CNT_W-1:0] cnt, lim;
  tick_ctrl_t       ctrl, ctrl_wdata;
  logic             expire;
  logic [NTHREADS-1:0] mask, pend;
  logic [DATA_W-1:0]   rd_mux;

  assign sel_cnt  = (reg_addr == ADDR_W'(ADDR_CNT));
  assign sel_ctrl = (reg_addr == ADDR_W'(ADDR_CTRL));
  assign sel_lim  = (reg_addr == ADDR_W'(ADDR_LIM));
  assign sel_mask = (reg_addr == ADDR_W'(ADDR_MASK));
  assign sel_tid  = (reg_addr == ADDR_W'(ADDR_TID));

  assign ctrl_wdata.irq_en    = reg_wdata[0];
  assign ctrl_wdata.gate_halt = reg_wdata[1];

  ttt_counter #(.CW(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .cnt_we      (reg_wr_en && sel_cnt),
    .lim_we      (reg_wr_en && sel_lim),
    .ctrl_we     (reg_wr_en && sel_ctrl),
    .wdata       (reg_wdata[CNT_W-1:0]),
    .ctrl_wdata  (ctrl_wdata),
    .core_halted (&thread_halted),
    .cnt         (cnt),
    .lim         (lim),
    .ctrl        (ctrl),
    .expire      (expire)
  );

  ttt_fanout #(.NT(NTHREADS)) u_fan (
    .clk        (clk),
    .rst        (rst),
    .mask_we    (reg_wr_en && sel_mask),
    .mask_wdata (reg_wdata[NTHREADS-1:0]),
    .ctrl_we    (reg_wr_en && sel_ctrl),
    .expire     (expire),
    .mask       (mask),
    .pend       (pend)
  );

  always_comb begin
    rd_mux = '0;
    if (sel_cnt)       rd_mux = DATA_W'(cnt);
    else if (sel_ctrl) rd_mux = DATA_W'(ctrl);
    else if (sel_lim)  rd_mux = DATA_W'(lim);
    else if (sel_mask) rd_mux = DATA_W'(mask);
    else if (sel_tid)  rd_mux = DATA_W'(reg_tid);
  end

  always_ff @(posedge clk) begin
    if (rst)            reg_rdata <= '0;
    else if (reg_rd_en) reg_rdata <= rd_mux;
  end

  assign irq_out = pend;

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && !(sel_cnt || sel_ctrl || sel_lim || sel_mask || sel_tid))
      |=> (reg_rdata == '0)); // R2
  AST_TID_READBACK: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && sel_tid) |=> (reg_rdata == DATA_W'($past(reg_tid)))); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_en |=> $stable(reg_rdata)); // R2
  AST_TID_W: assert property (@(posedge clk) TIDW <= DATA_W); // R10
endmodule

// File: tb/thread_tick_timer_test.sv
`timescale 1ns/1ps
module thread_tick_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_tid = '0;
  logic [31:0] reg_rdata;
  logic [15:0] thread_halted = '0;
  logic [15:0] irq_out;

  int vectors = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [31:0] m_cnt = '0, m_lim = '0, m_rdata = '0;
  logic [1:0]  m_ctrl = '0;
  logic [15:0] m_mask = '0, m_pend = '0;

  always #2.5 clk = ~clk;

  thread_tick_timer uut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_tid(reg_tid),
    .reg_rdata(reg_rdata), .thread_halted(thread_halted), .irq_out(irq_out)
  );

  task automatic step();
    logic [31:0] c_n, l_n, r_n;
    logic [1:0]  k_n;
    logic [15:0] m_n, p_n;
    bit tk, ex;
    if (rst) begin
      c_n = 0; l_n = 0; r_n = 0; k_n = 0; m_n = 0; p_n = 0;
    end else begin
      tk = !(m_ctrl[1] && (thread_halted == 16'hFFFF));
      ex = tk && (m_cnt == m_lim) && m_ctrl[0];
      c_n = m_cnt; l_n = m_lim; k_n = m_ctrl; m_n = m_mask; r_n = m_rdata;
      if (tk) c_n = (m_cnt == m_lim) ? 32'd0 : m_cnt + 32'd1;
      p_n = m_pend | (ex ? m_mask : 16'h0);
      if (reg_rd_en) begin
        case (reg_addr)
          8'h21: r_n = m_cnt;
          8'h22: r_n = {30'd0, m_ctrl};
          8'h23: r_n = m_lim;
          8'h50: r_n = {16'd0, m_mask};
          8'h51: r_n = {28'd0, reg_tid};
          default: r_n = 0;
        endcase
      end
      if (reg_wr_en) begin
        case (reg_addr)
          8'h21: c_n = reg_wdata;
          8'h22: begin k_n = reg_wdata[1:0]; p_n = 0; end
          8'h23: l_n = reg_wdata;
          8'h50: begin m_n = reg_wdata[15:0]; p_n = p_n & reg_wdata[15:0]; end
          default: ;
        endcase
      end
    end
    @(posedge clk);
    #1;
    m_cnt = c_n; m_lim = l_n; m_ctrl = k_n; m_mask = m_n; m_pend = p_n; m_rdata = r_n;
    vectors++;
    if (irq_out !== m_pend) begin
      fails++;
      $display("FAIL %s irq_out actual=%h expected=%h", cur_req, irq_out, m_pend);
    end
    if (reg_rdata !== m_rdata) begin
      fails++;
      $display("FAIL %s reg_rdata actual=%h expected=%h", cur_req, reg_rdata, m_rdata);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    reg_rd_en = 1; reg_addr = a;
    step();
    reg_rd_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    cur_req = "R1";
    idle(3);
    rst = 0;
    rd(8'h21); rd(8'h22); rd(8'h23); rd(8'h50);

    cur_req = "R2";
    wr(8'h23, 32'd5); rd(8'h23);
    rd(8'h10);
    wr(8'h22, 32'hFFFF_FFFC); rd(8'h22);
    wr(8'h22, 32'h3); rd(8'h22);
    wr(8'h22, 32'h0);

    cur_req = "R3";
    reg_wr_en = 1; reg_rd_en = 1; reg_addr = 8'h23; reg_wdata = 32'd9;
    step();
    reg_wr_en = 0; reg_rd_en = 0;
    rd(8'h23);

    cur_req = "R10";
    reg_tid = 4'd7; rd(8'h51);
    reg_tid = 4'd12; rd(8'h51);

    cur_req = "R7";
    wr(8'h50, 32'h0000_80A5);
    wr(8'h23, 32'd3); wr(8'h21, 32'd0); wr(8'h22, 32'h3);
    idle(12);
    rd(8'h21);

    cur_req = "R9";
    wr(8'h50, 32'h0000_8005);
    idle(2);
    wr(8'h22, 32'h3);
    idle(6);
    wr(8'h50, 32'h0000_0000);
    idle(5);

    cur_req = "R8";
    wr(8'h50, 32'h0000_FFFF);
    wr(8'h22, 32'h2);
    idle(10);

    cur_req = "R6";
    thread_halted = 16'hFFFF;
    rd(8'h21); idle(5); rd(8'h21);
    thread_halted = 16'h7FFF;
    idle(3); rd(8'h21);
    thread_halted = 16'hFFFF;
    wr(8'h22, 32'h0);
    idle(3); rd(8'h21);
    thread_halted = 16'h0;

    cur_req = "R5";
    wr(8'h23, 32'd6);
    wr(8'h21, 32'd5);
    wr(8'h22, 32'h3);
    idle(4); rd(8'h21);

    cur_req = "R4";
    wr(8'h23, 32'd0); wr(8'h21, 32'd0); wr(8'h22, 32'h1);
    idle(4); rd(8'h21);
    wr(8'h23, 32'd2); wr(8'h21, 32'd0);
    for (int i = 0; i < 7; i++) rd(8'h21);

    cur_req = "R1";
    rst = 1; idle(2); rst = 0;
    rd(8'h50); rd(8'h23);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule